// File: doc/BRIEF.md
# CAN Controller Power-Mode Sequencer

This block decides when a CAN controller sleeps and when it wakes. Software asks for sleep by writing code 01 into a 2-bit power-save field. It asks for a change of operating mode, either normal operation or initialization, through single-cycle request pulses. All requests wait until the protocol engine reports an idle bus. While the controller sleeps, the block stops the internal operating clock. It also refuses every CPU register write other than the power-save field, and it refuses all access to message buffers.

There are two ways to wake the controller. Software can write 00 into the power-save field, or the receive pin can fall from recessive to dominant. The receive pin passes through a synchronizer before the falling edge is detected. A wake caused by bus activity latches a wake status bit, and the block then returns to the operating mode it held before sleep. The buffer-ready flag stays low after wake until the bus has shown a run of consecutive recessive bit samples. Only then does the controller take part in bus traffic again. Because of this, the frame whose start edge caused the wake is never stored.

A module clock enable freezes the whole block while it is low. A controller that sleeps with its clock removed stays asleep until the clock returns.

Top module: `can_pwr_seq`

## Requirements
- R1: `psave_q` reads 01 while a sleep request is pending or the block is asleep, and reads 00 at all other times. A write of 01 asks for sleep. A write of 00 withdraws a pending request or wakes the block. Codes 10 and 11 have no effect.
- R2: `op_clk_en` is low whenever the block is asleep or `mod_clk_en` is low. It is high at all other times.
- R3: A write of 00 to the power-save field while asleep clears `sleeping` at that clock edge.
- R4: A falling edge on `rx_pin` wakes a sleeping block. `sleeping` clears on the third rising clock edge after the pin falls. A falling edge while the block is awake changes nothing.
- R5: `mode_q` (00 = initialization, 01 = normal operation) keeps the same value through sleep and wake.
- R6: `wake_irq` is set by a bus wake and is not set by a CPU wake. A `wake_clr` pulse clears it, and a set in the same cycle takes priority over the clear.
- R7: `buf_rdy` is 1 after reset and clears on entry to sleep. After a wake it rises at the strobe that completes 11 consecutive recessive `bit_strobe` samples. A dominant sample starts the count again.
- R8: `req_init` and `req_op` pulses given while asleep are ignored. The mode stays the same after the later wake.
- R9: An initialization request cancels a sleep request that is pending or given in the same cycle. A sleep request given while an initialization request is pending is dropped at once, so `psave_q` stays 00.
- R10: A pending request is granted only in a cycle with `bus_idle` high. A request is first eligible in the cycle after the one in which it was made. When both mode requests are pending, initialization wins.
- R11: While asleep, `reg_wr_ok` is low. `buf_acc_ok` is high only when `cpu_buf_acc` is high, the block is awake and `buf_rdy` is 1.
- R12: While `mod_clk_en` is low, all state holds and no wake occurs. The falling edge is acted on once the clock returns, and the wake follows on the third edge after that.
- R13: If a bus falling edge arrives in the cycle in which sleep would be granted, `sleeping` never rises. In that case `wake_irq` sets, `psave_q` returns to 00 and `buf_rdy` clears until the block rejoins the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_clk_en | input | 1 | Module clock enable; freezes all state when low |
| bus_idle | input | 1 | Protocol engine reports that the bus is between frames |
| psave_wr | input | 1 | CPU write strobe for the power-save field |
| psave_wdata | input | 2 | Power-save write value: 00 run, 01 sleep |
| req_op | input | 1 | Request for normal operation mode |
| req_init | input | 1 | Request for initialization mode |
| rx_pin | input | 1 | CAN receive pin, asynchronous (1 = recessive) |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| wake_clr | input | 1 | Clears the wake status bit |
| cpu_reg_wr | input | 1 | CPU write attempt to any other controller register |
| cpu_buf_acc | input | 1 | CPU access attempt to message buffers |
| op_clk_en | output | 1 | Internal operating clock enable |
| sleeping | output | 1 | Block is asleep |
| psave_q | output | 2 | Power-save field read value |
| mode_q | output | 2 | Current operating mode: 00 initialization, 01 normal |
| wake_irq | output | 1 | Wake-by-bus status bit |
| buf_rdy | output | 1 | Message buffers are usable and the controller is on the bus |
| reg_wr_ok | output | 1 | Register write attempt is allowed |
| buf_acc_ok | output | 1 | Buffer access attempt is allowed |

## Verification
A corrupted sleep flag shows up at once on `op_clk_en`, `reg_wr_ok` and `psave_q`, in the same cycle. A lost or wrongly retained pending request shows on `psave_q` one edge after the request, or on `mode_q` at the next idle-bus grant. A fault in the synchronizer or in the edge detector moves the wake away from the third edge after the pin falls, and the bench samples exactly at that edge. Faults in the rejoin counter surface only at the 11th recessive strobe, so the bench stops just short of that count and then again just after it.

// File: rtl/can_pwr_pkg.sv
// Shared encodings for the CAN power-mode sequencer.
// Assumes: mode and power-save codes are visible to software and must not change.
package can_pwr_pkg;

    typedef enum logic [1:0] {
        MODE_INIT = 2'b00,
        MODE_NORM = 2'b01
    } opmode_e;

    localparam logic [1:0] PS_RUN   = 2'b00;
    localparam logic [1:0] PS_SLEEP = 2'b01;

endpackage

// File: rtl/can_rx_edge.sv
// Receive-pin synchronizer and recessive-to-dominant edge detector.
// Does: brings the asynchronous pin through SYNC_STAGES flops and flags a
// 1->0 change of the synchronized level. Stays active during sleep.
// Assumes: en freezes the chain (module clock removed); reset level is recessive.
module can_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rx_pin,
    output logic rx_s,
    output logic fall
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the pin level through the synchronizer chain.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n)  sync_q[g] <= 1'b1;
                else if (en) sync_q[g] <= (g == 0) ? rx_pin : sync_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)  prev_q <= 1'b1;
        else if (en) prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rx_s = sync_q[SYNC_STAGES-1];
    assign fall = en & prev_q & ~rx_s;

endmodule

// File: rtl/can_pwr_fsm.sv
// Sleep/mode state machine.
// Does: queues mode and sleep requests, grants them on an idle bus with
// initialization first, enters and leaves sleep, latches the wake status bit.
// Assumes: fall is already synchronized; en low freezes everything.
module can_pwr_fsm
    import can_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bus_idle,
    input  logic       psave_wr,
    input  logic [1:0] psave_wdata,
    input  logic       req_op,
    input  logic       req_init,
    input  logic       fall,
    input  logic       wake_clr,
    output logic       asleep,
    output logic [1:0] psave_q,
    output opmode_e    mode,
    output logic       wake_irq,
    output logic       enter_slp,
    output logic       wake_start
);
    logic asleep_q, slp_pend_q, init_pend_q, op_pend_q, irq_q;
    opmode_e mode_q;

    logic wr_run, wr_sleep, wake_now, bus_wake, slp_grant, clash;

    // Decode the write and wake conditions of this cycle.
    always_comb begin
        wr_run    = psave_wr && (psave_wdata == PS_RUN);
        wr_sleep  = psave_wr && (psave_wdata == PS_SLEEP);
        bus_wake  = asleep_q && fall;
        wake_now  = (asleep_q && wr_run) || bus_wake;
        slp_grant = !asleep_q && bus_idle && slp_pend_q;
        clash     = slp_grant && fall;
    end

    assign enter_slp  = en && slp_grant && !fall;
    assign wake_start = en && (wake_now || clash);

    // Request queues, mode register and sleep flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q    <= 1'b0;
            slp_pend_q  <= 1'b0;
            init_pend_q <= 1'b0;
            op_pend_q   <= 1'b0;
            mode_q      <= MODE_INIT;
        end else if (en) begin
            if (asleep_q) begin
                if (wake_now) asleep_q <= 1'b0;
                slp_pend_q <= 1'b0;
            end else begin
                init_pend_q <= (init_pend_q && !bus_idle) || req_init;
                op_pend_q   <= (op_pend_q && !bus_idle) || req_op;
                if (bus_idle && init_pend_q)    mode_q <= MODE_INIT;
                else if (bus_idle && op_pend_q) mode_q <= MODE_NORM;
                if (req_init || init_pend_q) slp_pend_q <= 1'b0;
                else if (wr_sleep)           slp_pend_q <= 1'b1;
                else if (wr_run || slp_grant) slp_pend_q <= 1'b0;
                asleep_q <= slp_grant && !fall;
            end
        end
    end

    // Wake status bit: set by bus wake, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else if (en) begin
            if (bus_wake || clash) irq_q <= 1'b1;
            else if (wake_clr)     irq_q <= 1'b0;
        end
    end

    assign asleep   = asleep_q;
    assign psave_q  = (asleep_q || slp_pend_q) ? PS_SLEEP : PS_RUN;
    assign mode     = mode_q;
    assign wake_irq = irq_q;

    a_r3_cpu_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (en && asleep_q && psave_wr && psave_wdata == PS_RUN) |=> !asleep_q);
    a_r5_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_q |=> $stable(mode_q));
    a_r6_bus_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (en && asleep_q && fall) |=> irq_q);
    a_r8_init_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (en && asleep_q && req_init) |=> !init_pend_q);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        init_pend_q |-> !slp_pend_q);

endmodule

// File: rtl/can_rejoin.sv
// Bus-rejoin counter and buffer-ready flag.
// Does: after a wake, counts consecutive recessive samples at the bit strobe
// and raises rdy once RECESSIVE_BITS have been seen; a dominant sample restarts.
// Assumes: start and enter are never high together.
module can_rejoin #(
    parameter int RECESSIVE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic enter,
    input  logic strobe,
    input  logic rx_s,
    output logic rdy
);
    localparam int CW = $clog2(RECESSIVE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(RECESSIVE_BITS - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q, rdy_q;

    // Track the rejoin window and the recessive run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q    <= 1'b1;
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (en) begin
            if (start) begin
                rdy_q    <= 1'b0;
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (enter) begin
                rdy_q    <= 1'b0;
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else if (active_q && strobe) begin
                if (!rx_s) cnt_q <= '0;
                else if (cnt_q == LAST) begin
                    rdy_q    <= 1'b1;
                    active_q <= 1'b0;
                    cnt_q    <= '0;
                end else cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rdy = rdy_q;

    a_r7_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> $past(strobe && rx_s && en));

endmodule

// File: rtl/can_pwr_seq.sv
// Top of the CAN power-mode sequencer.
// Does: ties edge detector, mode FSM and rejoin counter together and gates
// the operating clock and CPU access.
// Assumes: all inputs except rx_pin are synchronous to clk.
module can_pwr_seq
    import can_pwr_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int RECESSIVE_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_clk_en,
    input  logic       bus_idle,
    input  logic       psave_wr,
    input  logic [1:0] psave_wdata,
    input  logic       req_op,
    input  logic       req_init,
    input  logic       rx_pin,
    input  logic       bit_strobe,
    input  logic       wake_clr,
    input  logic       cpu_reg_wr,
    input  logic       cpu_buf_acc,
    output logic       op_clk_en,
    output logic       sleeping,
    output logic [1:0] psave_q,
    output logic [1:0] mode_q,
    output logic       wake_irq,
    output logic       buf_rdy,
    output logic       reg_wr_ok,
    output logic       buf_acc_ok
);
    logic    rx_s, fall, asleep, enter_slp, wake_start;
    opmode_e mode;

    can_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk(clk), .rst_n(rst_n), .en(mod_clk_en), .rx_pin(rx_pin),
        .rx_s(rx_s), .fall(fall)
    );

    can_pwr_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .en(mod_clk_en), .bus_idle(bus_idle),
        .psave_wr(psave_wr), .psave_wdata(psave_wdata), .req_op(req_op),
        .req_init(req_init), .fall(fall), .wake_clr(wake_clr),
        .asleep(asleep), .psave_q(psave_q), .mode(mode), .wake_irq(wake_irq),
        .enter_slp(enter_slp), .wake_start(wake_start)
    );

    can_rejoin #(.RECESSIVE_BITS(RECESSIVE_BITS)) i_rejoin (
        .clk(clk), .rst_n(rst_n), .en(mod_clk_en), .start(wake_start),
        .enter(enter_slp), .strobe(bit_strobe), .rx_s(rx_s), .rdy(buf_rdy)
    );

    // Clock gate and CPU access gating.
    always_comb begin
        op_clk_en  = mod_clk_en && !asleep;
        reg_wr_ok  = cpu_reg_wr && !asleep;
        buf_acc_ok = cpu_buf_acc && buf_rdy && !asleep;
    end

    assign sleeping = asleep;
    assign mode_q   = mode;

    a_r7_rdy_low_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !buf_rdy);
    a_r12_clk_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_clk_en |=> ($stable(asleep) && $stable(psave_q)));

endmodule

// File: tb/test_can_pwr_seq.sv
`timescale 1ns/1ps
module test_can_pwr_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_clk_en = 1'b1, bus_idle = 1'b0, psave_wr = 1'b0;
    logic [1:0] psave_wdata = 2'b00;
    logic       req_op = 1'b0, req_init = 1'b0, rx_pin = 1'b1, bit_strobe = 1'b0;
    logic       wake_clr = 1'b0, cpu_reg_wr = 1'b0, cpu_buf_acc = 1'b0;
    logic       op_clk_en, sleeping, wake_irq, buf_rdy, reg_wr_ok, buf_acc_ok;
    logic [1:0] psave_q, mode_q;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    can_pwr_seq i_can_pwr_seq (
        .clk(clk), .rst_n(rst_n), .mod_clk_en(mod_clk_en), .bus_idle(bus_idle),
        .psave_wr(psave_wr), .psave_wdata(psave_wdata), .req_op(req_op),
        .req_init(req_init), .rx_pin(rx_pin), .bit_strobe(bit_strobe),
        .wake_clr(wake_clr), .cpu_reg_wr(cpu_reg_wr), .cpu_buf_acc(cpu_buf_acc),
        .op_clk_en(op_clk_en), .sleeping(sleeping), .psave_q(psave_q),
        .mode_q(mode_q), .wake_irq(wake_irq), .buf_rdy(buf_rdy),
        .reg_wr_ok(reg_wr_ok), .buf_acc_ok(buf_acc_ok)
    );

    // {req_init, req_op, psave_wr, psave_wdata[1:0], bus_idle,
    //  exp mode_q[1:0], exp psave_q[1:0], exp sleeping}
    // Covers R1, R5, R8, R9, R10 step by step from reset.
    localparam logic [10:0] VEC [0:15] = '{
        11'b01000000000, 11'b00000000000, 11'b00000101000, 11'b00101001010,
        11'b00000101011, 11'b10000101011, 11'b00100101000, 11'b10101001000,
        11'b00101001000, 11'b00000100000, 11'b00101000010, 11'b10000000000,
        11'b00000100000, 11'b00101100010, 11'b00000100011, 11'b00100100000
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep();
        bus_idle = 1'b1; psave_wr = 1'b1; psave_wdata = 2'b01;
        cyc(1);
        psave_wr = 1'b0;
        cyc(1);
    endtask

    task automatic strobe(input int n);
        for (int k = 0; k < n; k++) begin
            bit_strobe = 1'b1; cyc(1);
            bit_strobe = 1'b0; cyc(1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // Reset state (R1, R2, R5, R6, R7)
        check("R1 reset psave", psave_q, 2'b00);
        check("R5 reset mode", mode_q, 2'b00);
        check("R2 reset clock", {op_clk_en, sleeping}, 2'b10);
        check("R6 reset irq", wake_irq, 1'b0);
        check("R7 reset rdy", buf_rdy, 1'b1);

        // Table walk
        cpu_reg_wr = 1'b1;
        for (int i = 0; i < 16; i++) begin
            {req_init, req_op, psave_wr, psave_wdata, bus_idle} = VEC[i][10:5];
            cyc(1);
            check($sformatf("R1/R5/R8/R9/R10 step %0d", i),
                  {mode_q, psave_q, sleeping}, VEC[i][4:0]);
            check($sformatf("R2/R11 step %0d", i),
                  {op_clk_en, reg_wr_ok}, {2{~VEC[i][0]}});
        end
        {req_init, req_op, psave_wr, psave_wdata} = '0;

        // Bus wake (R4, R6, R7, R11)
        cpu_buf_acc = 1'b1;
        go_sleep();
        check("R7 rdy cleared on sleep", buf_rdy, 1'b0);
        check("R11 access blocked", {reg_wr_ok, buf_acc_ok, op_clk_en}, 3'b000);
        rx_pin = 1'b0;
        cyc(2);
        check("R4 still asleep after two edges", sleeping, 1'b1);
        cyc(1);
        check("R4 woke on third edge", {sleeping, psave_q}, 3'b000);
        check("R6 irq on bus wake", wake_irq, 1'b1);
        check("R11 waking frame not stored", {buf_rdy, buf_acc_ok}, 2'b00);

        // Rejoin count (R7)
        strobe(2);
        rx_pin = 1'b1; cyc(3);
        strobe(10);
        check("R7 not ready after 10", buf_rdy, 1'b0);
        rx_pin = 1'b0; cyc(3);
        strobe(1);
        rx_pin = 1'b1; cyc(3);
        strobe(10);
        check("R7 restart after dominant", buf_rdy, 1'b0);
        strobe(1);
        check("R7 ready after 11", {buf_rdy, buf_acc_ok}, 2'b11);

        // CPU wake and awake edge (R3, R4, R6)
        wake_clr = 1'b1; cyc(1); wake_clr = 1'b0;
        check("R6 irq cleared", wake_irq, 1'b0);
        rx_pin = 1'b0; cyc(4);
        check("R4 edge ignored awake", {sleeping, wake_irq, psave_q}, 4'b0000);
        rx_pin = 1'b1; cyc(3);
        go_sleep();
        check("R2 asleep gate", {sleeping, op_clk_en}, 2'b10);
        psave_wr = 1'b1; psave_wdata = 2'b00; cyc(1); psave_wr = 1'b0;
        check("R3 cpu wake", {sleeping, psave_q}, 3'b000);
        check("R6 no irq on cpu wake", wake_irq, 1'b0);

        // Clock removed during sleep (R12, R2)
        go_sleep();
        mod_clk_en = 1'b0; rx_pin = 1'b0;
        cyc(6);
        check("R12 held asleep", {sleeping, psave_q}, 3'b101);
        check("R2 clock off", op_clk_en, 1'b0);
        mod_clk_en = 1'b1;
        cyc(2);
        check("R12 not yet awake", sleeping, 1'b1);
        cyc(1);
        check("R12 wake after clock back", {sleeping, wake_irq}, 2'b01);
        rx_pin = 1'b1; wake_clr = 1'b1; cyc(1); wake_clr = 1'b0; cyc(3);

        // Edge on the sleep grant cycle (R13)
        bus_idle = 1'b0; psave_wr = 1'b1; psave_wdata = 2'b01; rx_pin = 1'b0;
        cyc(1);
        psave_wr = 1'b0;
        check("R13 pending before grant", {sleeping, psave_q}, 3'b001);
        cyc(1);
        bus_idle = 1'b1;
        check("R13 still awake", sleeping, 1'b0);
        cyc(1);
        check("R13 never slept", {sleeping, psave_q, wake_irq}, 4'b0001);
        check("R13 rdy cleared", buf_rdy, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule